// File: doc/BRIEF.md
# Stop-State Wake Sequencer

This block governs a processor core's low-power stop state. A decoded stop request gates the core clock off. The core stays halted until a wake interrupt line is raised, or until the block's reset is applied. A wake through the interrupt line starts a clock-stabilisation count. A mode input selects its length: a long count for a freshly started internal oscillator, or a short one for a clock that is already stable. While that count runs, a flush output tells the interrupt logic to clear and ignore the peripheral and external interrupt classes. Trace and stack-error interrupts are not covered by the flush.

When the count expires, a fixed tail of 17 cycles follows. This tail covers the remaining stop cycles up to the first instruction fetch. At the end of the tail the core clock is re-enabled and a one-cycle resume strobe is issued. At the same moment the block decides whether the wake interrupt becomes pending. That requires three things:
- the wake line was configured level-sensitive;
- the line stayed asserted from the end of the count through the last tail cycle;
- no higher-level interrupt was pending.

If the line is already asserted when the stop request arrives, the clock generator is never stopped. The block goes straight into the count, and the stop acts as a long no-op. Reset ends the stop state at once, with no count and with all pending state discarded.

Top module: `stopwake_unit`

## Requirements
- R1: While `rstN` is low, `coreClkEn` is 1 and `resumeStb`, `irqaPend` and `flushExtIrq` are 0. Asserting reset during a stop restores `coreClkEn` at once, without any count.
- R2: A `stopReq` sampled high while running with the synchronised wake line low drops `coreClkEn` in the next cycle. The enable stays low for as long as `irqWake` stays low.
- R3: `quickWake`=1 selects a 16-cycle count and `quickWake`=0 a 131072-cycle count. The value is sampled when the count is loaded. Counted from the first clock edge that samples `irqWake` high during a halt, `coreClkEn` stays low for count+19 edges: 2 synchroniser edges, the count, and a 17-cycle tail.
- R4: `flushExtIrq` is high for exactly the count's cycles and never while `coreClkEn` is high.
- R5: `resumeStb` is a single-cycle pulse, high in the first cycle in which `coreClkEn` is high again.
- R6: `irqaPend` is set at resume only under three conditions. First, `irqWake` was high at every edge from the count's last edge through the last tail edge. Second, `levelSense` was 1. Third, `higherPend` was 0. Otherwise it stays 0; releasing `irqWake` at, before or just after the end of the count gives 0.
- R7: A `stopReq` that arrives while the synchronised wake line is already high skips the halt and enters the count directly. `coreClkEn` is then low for count+17 cycles, and the pending rule of R6 still applies.
- R8: Once set, `irqaPend` holds until the next accepted `stopReq` (cleared one edge later) or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock (one T cycle) |
| rstN | input | 1 | Asynchronous active-low reset; also the reset-wake path |
| stopReq | input | 1 | Decoded stop instruction strobe |
| irqWake | input | 1 | Asynchronous wake interrupt line, active high |
| quickWake | input | 1 | 1: short stabilisation count, 0: long count |
| levelSense | input | 1 | Wake line configured as level sensitive |
| higherPend | input | 1 | An interrupt of higher level is pending |
| coreClkEn | output | 1 | Core clock enable |
| resumeStb | output | 1 | One-cycle strobe when execution resumes |
| irqaPend | output | 1 | Wake interrupt recorded as pending |
| flushExtIrq | output | 1 | Clear/ignore peripheral and external interrupts |

## Verification
The end of the stabilisation count and the first sample of the wake line's hold window fall on the same clock edge. An off-by-one in either shows up only when the line is released in the cycles around that edge. The bench provokes this by releasing the line exactly at the count's end, one tail cycle too early, and on the last edge that still qualifies. It judges each case by the pending flag seen in the cycle where the resume strobe appears. The second coincidence is a stop request whose wake line is already high, which merges halt entry and count start into one edge. That case is judged by the shorter clock-off length.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_DELAY = 2'd2,
    ST_TAIL  = 2'd3
  } swState_t;

  typedef struct packed {
    logic loadDelay;
    logic runDelay;
    logic loadTail;
    logic runTail;
  } swStrobe_t;

endpackage

// File: rtl/stopwake_datapath.sv
module stopwake_datapath
  import stopwake_pkg::*;
#(
  parameter int LONG_DELAY  = 131072,
  parameter int SHORT_DELAY = 16,
  parameter int TAIL_LEN    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqWake,
  input  logic      quickWake,
  input  swStrobe_t strobe,
  output logic      syncIrq,
  output logic      delayZero,
  output logic      tailZero,
  output logic      wakeHeld
);

  localparam int DCNT_W = $clog2(LONG_DELAY);
  localparam int TCNT_W = $clog2(TAIL_LEN);
  localparam logic [DCNT_W-1:0] LONG_M1  = DCNT_W'(LONG_DELAY - 1);
  localparam logic [DCNT_W-1:0] SHORT_M1 = DCNT_W'(SHORT_DELAY - 1);
  localparam logic [TCNT_W-1:0] TAIL_M1  = TCNT_W'(TAIL_LEN - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DCNT_W-1:0]      delayCnt;
  logic [TCNT_W-1:0]      tailCnt;
  logic                   heldFlag;

  // wake line synchroniser, one flop per stage
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= irqWake;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign syncIrq = syncChain[SYNC_STAGES-1];

  // stabilisation down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strobe.loadDelay) begin
      delayCnt <= quickWake ? SHORT_M1 : LONG_M1;
    end else if (strobe.runDelay && delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  assign delayZero = (delayCnt == '0);

  // tail counter for the remaining stop cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailCnt <= '0;
    end else if (strobe.loadTail) begin
      tailCnt <= TAIL_M1;
    end else if (strobe.runTail && tailCnt != '0) begin
      tailCnt <= tailCnt - 1'b1;
    end
  end

  assign tailZero = (tailCnt == '0);

  // wake line must stay high from the count's end through the tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldFlag <= 1'b0;
    end else if (strobe.loadTail) begin
      heldFlag <= syncIrq;
    end else if (strobe.runTail) begin
      heldFlag <= heldFlag & syncIrq;
    end
  end

  assign wakeHeld = heldFlag & syncIrq;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDelay |=> (delayCnt == LONG_M1 || delayCnt == SHORT_M1)); // R3
  AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTail |=> (tailCnt == TAIL_M1)); // R3
  AST_COUNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.runDelay && strobe.runTail)); // R4

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      levelSense,
  input  logic      higherPend,
  input  logic      syncIrq,
  input  logic      delayZero,
  input  logic      tailZero,
  input  logic      wakeHeld,
  output swStrobe_t strobe,
  output logic      coreClkEn,
  output logic      resumeStb,
  output logic      irqaPend,
  output logic      flushExtIrq
);

  swState_t state, stateNext;
  logic     stopTaken;
  logic     tailEnd;

  assign stopTaken = (state == ST_RUN) && stopReq;
  assign tailEnd   = (state == ST_TAIL) && tailZero;

  always_comb begin
    strobe.loadDelay = (stopTaken && syncIrq) || (state == ST_HALT && syncIrq);
    strobe.runDelay  = (state == ST_DELAY);
    strobe.loadTail  = (state == ST_DELAY) && delayZero;
    strobe.runTail   = (state == ST_TAIL);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (stopReq)   stateNext = syncIrq ? ST_DELAY : ST_HALT;
      ST_HALT:  if (syncIrq)   stateNext = ST_DELAY;
      ST_DELAY: if (delayZero) stateNext = ST_TAIL;
      ST_TAIL:  if (tailZero)  stateNext = ST_RUN;
      default:                 stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeStb <= 1'b0;
      irqaPend  <= 1'b0;
    end else begin
      resumeStb <= tailEnd;
      if (stopTaken)    irqaPend <= 1'b0;
      else if (tailEnd) irqaPend <= wakeHeld & levelSense & ~higherPend;
    end
  end

  assign coreClkEn   = (state == ST_RUN);
  assign flushExtIrq = (state == ST_DELAY);

  AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !syncIrq) |=> (state == ST_HALT)); // R2
  AST_FLUSH_CLK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    flushExtIrq |-> !coreClkEn); // R4
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resumeStb |=> !resumeStb); // R5
  AST_RESUME_CLK_ON: assert property (@(posedge clk) disable iff (!rstN)
    resumeStb |-> coreClkEn); // R5
  AST_PEND_AT_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqaPend) |-> resumeStb); // R6
  AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqaPend) |-> $past(levelSense) && !$past(higherPend)); // R6
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stopTaken |=> !irqaPend); // R8

endmodule

// File: rtl/stopwake_unit.sv
module stopwake_unit
  import stopwake_pkg::*;
#(
  parameter int LONG_DELAY  = 131072,
  parameter int SHORT_DELAY = 16,
  parameter int TAIL_LEN    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic irqWake,
  input  logic quickWake,
  input  logic levelSense,
  input  logic higherPend,
  output logic coreClkEn,
  output logic resumeStb,
  output logic irqaPend,
  output logic flushExtIrq
);

  swStrobe_t strobe;
  logic      syncIrq;
  logic      delayZero;
  logic      tailZero;
  logic      wakeHeld;

  stopwake_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .levelSense (levelSense),
    .higherPend (higherPend),
    .syncIrq    (syncIrq),
    .delayZero  (delayZero),
    .tailZero   (tailZero),
    .wakeHeld   (wakeHeld),
    .strobe     (strobe),
    .coreClkEn  (coreClkEn),
    .resumeStb  (resumeStb),
    .irqaPend   (irqaPend),
    .flushExtIrq(flushExtIrq)
  );

  stopwake_datapath #(
    .LONG_DELAY (LONG_DELAY),
    .SHORT_DELAY(SHORT_DELAY),
    .TAIL_LEN   (TAIL_LEN),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .irqWake  (irqWake),
    .quickWake(quickWake),
    .strobe   (strobe),
    .syncIrq  (syncIrq),
    .delayZero(delayZero),
    .tailZero (tailZero),
    .wakeHeld (wakeHeld)
  );

endmodule

// File: tb/stopwake_unit_test.sv
module stopwake_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_N    = 16;
  localparam int LONG_N     = 131072;

  typedef struct packed {
    logic        pre;
    logic        level;
    logic        higher;
    logic [15:0] hold;
    logic        expPend;
    logic [15:0] expLow;
  } vec_t;

  localparam int NV = 10;
  // short count (16): halt path low 16+19=35, pre-asserted path low 16+17=33
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 16'd34, 1'b1, 16'd35},  // held exactly long enough
    '{1'b0, 1'b1, 1'b0, 16'd33, 1'b0, 16'd35},  // released on last tail edge
    '{1'b0, 1'b1, 1'b0, 16'd16, 1'b0, 16'd35},  // released at count end
    '{1'b0, 1'b1, 1'b0, 16'd17, 1'b0, 16'd35},  // released just after count end
    '{1'b0, 1'b1, 1'b0, 16'd10, 1'b0, 16'd35},  // released inside count
    '{1'b0, 1'b1, 1'b0, 16'd20, 1'b0, 16'd35},  // released mid tail
    '{1'b0, 1'b0, 1'b0, 16'd60, 1'b0, 16'd35},  // edge-configured line
    '{1'b0, 1'b1, 1'b1, 16'd60, 1'b0, 16'd35},  // higher level pending
    '{1'b1, 1'b1, 1'b0, 16'd60, 1'b1, 16'd33},  // stop with line high
    '{1'b1, 1'b0, 1'b0, 16'd60, 1'b0, 16'd33}   // stop with line high, edge cfg
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0;
  logic irqWake = 1'b0;
  logic quickWake = 1'b1;
  logic levelSense = 1'b1;
  logic higherPend = 1'b0;
  logic coreClkEn, resumeStb, irqaPend, flushExtIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stopwake_unit uut (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .irqWake    (irqWake),
    .quickWake  (quickWake),
    .levelSense (levelSense),
    .higherPend (higherPend),
    .coreClkEn  (coreClkEn),
    .resumeStb  (resumeStb),
    .irqaPend   (irqaPend),
    .flushExtIrq(flushExtIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wakeRun(input logic pre, input int hold, output int lowCnt,
                         output int flushCnt, output logic resAt, output logic pendAt);
    lowCnt = 0;
    flushCnt = 0;
    resAt = 1'b0;
    pendAt = 1'b0;
    if (pre) begin
      irqWake = 1'b1;
      repeat (3) @(negedge clk);
      stopReq = 1'b1;
    end else begin
      stopReq = 1'b1;
      @(negedge clk);
      stopReq = 1'b0;
      repeat (3) @(negedge clk);
      irqWake = 1'b1;
    end
    for (int cyc = 1; cyc < 140000; cyc++) begin
      @(negedge clk);
      stopReq = 1'b0;
      if (coreClkEn) begin
        resAt = resumeStb;
        pendAt = irqaPend;
        break;
      end
      lowCnt++;
      if (flushExtIrq) flushCnt++;
      if (!pre && cyc == hold) irqWake = 1'b0;
    end
    irqWake = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lowCnt, flushCnt;
    logic resAt, pendAt;

    repeat (3) @(negedge clk);
    chk("R1 clk enable in reset", int'(coreClkEn), 1);
    chk("R1 pend in reset", int'(irqaPend), 0);
    chk("R1 flush in reset", int'(flushExtIrq), 0);
    chk("R1 resume in reset", int'(resumeStb), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      levelSense = VECS[i].level;
      higherPend = VECS[i].higher;
      quickWake  = 1'b1;
      wakeRun(VECS[i].pre, int'(VECS[i].hold), lowCnt, flushCnt, resAt, pendAt);
      chk(VECS[i].pre ? "R7 clock-off length" : "R3 clock-off length", lowCnt, int'(VECS[i].expLow));
      chk("R4 flush length", flushCnt, SHORT_N);
      chk("R5 resume with clock", int'(resAt), 1);
      chk("R6 pend decision", int'(pendAt), int'(VECS[i].expPend));
      chk("R5 resume single cycle", int'(resumeStb), 0);
    end

    // R8: pend holds, then clears on next stop; R2: halt holds with line low
    levelSense = 1'b1;
    higherPend = 1'b0;
    wakeRun(1'b0, 60, lowCnt, flushCnt, resAt, pendAt);
    chk("R8 pend set", int'(pendAt), 1);
    repeat (5) @(negedge clk);
    chk("R8 pend holds", int'(irqaPend), 1);
    chk("R4 no flush when running", int'(flushExtIrq), 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8 pend cleared by stop", int'(irqaPend), 0);
    chk("R2 clock off after stop", int'(coreClkEn), 0);
    begin
      int onSeen = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (coreClkEn || flushExtIrq) onSeen++;
      end
      chk("R2 stays halted", onSeen, 0);
    end

    // R1: reset wakes at once, no count
    rstN = 1'b0;
    #1;
    chk("R1 reset wake clock", int'(coreClkEn), 1);
    chk("R1 reset wake pend", int'(irqaPend), 0);
    chk("R1 reset wake flush", int'(flushExtIrq), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 running after reset", int'(coreClkEn), 1);

    // R3: long count
    quickWake = 1'b0;
    wakeRun(1'b0, 32'h7fffffff, lowCnt, flushCnt, resAt, pendAt);
    chk("R3 long clock-off length", lowCnt, LONG_N + 19);
    chk("R4 long flush length", flushCnt, LONG_N);
    chk("R6 long pend", int'(pendAt), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule